// File: doc/BRIEF.md
# Parallel Flash Bus Interface Front-End

This block sits between the asynchronous pins of a parallel boot-block flash device and its synchronous internals. It samples chip enable, output enable, write enable and the bus-width select on a fast system clock and sorts the bus into one of five operations. Reads are turned into drive enables and a data word for the data pins. Writes become single-cycle command strobes that carry the latched address and data. A high chip enable is reported as standby.

A write follows the two-signal edge rules. The address is taken when the later of chip enable and write enable goes low. The data is taken when the earlier of the two returns high. A low pulse on either enable shorter than a set number of clock cycles is ignored. In 8-bit mode the top data pin serves as the lowest address bit, and the upper data pins are never driven. When the command logic selects identification mode, reads return the manufacturer and device codes in place of array data. A read that holds the same address for long enough is reported as automatic standby.

Top module: `pflash_front`

## Requirements
- R1: `bus_op` reports the current operation with the codes 0 standby, 1 read, 2 write, 3 output disable and 4 automatic standby.
- R2: With chip enable low, output enable low and write enable high, `dq_oe_lo` is high and `dq_out` equals `arr_data`, the array word at `rd_addr`, in 16-bit mode (`dq_oe_hi` also high).
- R3: A write latches its address when the later of chip enable and write enable falls. Address changes after that point have no effect on the write.
- R4: A write latches its data when the earlier of chip enable and write enable rises. It is then presented for one cycle on `cmd_valid`, with `cmd_addr` = {word address, low bit} (low bit 0 in 16-bit mode) and `cmd_data`.
- R5: If output enable is low while a write is in progress, `wr_proto_err` goes high and that write produces no `cmd_valid`.
- R6: While output enable is high, `dq_oe_lo` and `dq_oe_hi` are both low.
- R7: A low pulse on the enables lasting fewer than `GLITCH_CYC` sampled cycles is ignored: it starts no write and does not clear `standby`. A pulse of exactly `GLITCH_CYC` cycles is accepted.
- R8: With `bw16` low (8-bit mode), `dq_in[15]` is the low address bit. A read places byte 0 (bits 7:0) of the word when that bit is 0, or byte 1 (bits 15:8) when it is 1, on `dq_out[7:0]`; `dq_out[15:8]` is 0 and `dq_oe_hi` is low. A write takes `dq_in[7:0]` zero-extended as its data.
- R9: With `id_mode` high, a read returns 20h for address bits [1:0] = 00 and the device code for 01. The device code is D3h when `TOP_BOOT`=1 and D4h when `TOP_BOOT`=0. Both are zero-extended to 16 bits, and 00h is returned when address bit 1 is 1.
- R10: `standby` is high while chip enable is high, and it is never high while the data pins are driven.
- R11: `auto_standby` rises after `AUTO_IDLE` consecutive read cycles with an unchanged address. It falls within a few cycles of an address change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| bw16 | input | 1 | Bus width select: 1 = 16-bit, 0 = 8-bit |
| addr | input | ADDR_W | Word address pins |
| dq_in | input | 16 | Data pins as seen by the input buffers |
| id_mode | input | 1 | Identification read mode, from the command logic |
| arr_data | input | 16 | Array word at `rd_addr` |
| rd_addr | output | ADDR_W | Synchronized word address toward the array |
| dq_out | output | 16 | Value for the data pin output buffers |
| dq_oe_lo | output | 1 | Drive enable for data pins 7:0 |
| dq_oe_hi | output | 1 | Drive enable for data pins 15:8 |
| cmd_valid | output | 1 | One-cycle strobe for a captured write |
| cmd_addr | output | ADDR_W+1 | Byte address of the captured write |
| cmd_data | output | 16 | Data of the captured write |
| wr_proto_err | output | 1 | Output enable seen low during a write |
| standby | output | 1 | Chip deselected |
| auto_standby | output | 1 | Read idle with stable address |
| bus_op | output | 3 | Current bus operation code |

## Verification
The bench builds the block with `ADDR_W`=12, `GLITCH_CYC`=3 and `AUTO_IDLE`=16. With these values, two-cycle and three-cycle enable pulses fall on either side of the glitch threshold, and automatic standby is reached after a few dozen cycles. A second instance with `TOP_BOOT`=0 shares the same pins, so both device codes are read in one run. The small address width keeps the array model a simple function of the address.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  typedef enum logic [2:0] {
    OP_STANDBY = 3'd0,
    OP_READ    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_OUT_OFF = 3'd3,
    OP_AUTO_SB = 3'd4
  } bus_op_e;

  localparam logic [7:0] MFR_CODE     = 8'h20;
  localparam logic [7:0] DEV_CODE_TOP = 8'hD3;
  localparam logic [7:0] DEV_CODE_BOT = 8'hD4;

  // identification byte chosen by address bits [1:0]
  function automatic logic [7:0] ident_byte(input logic top_boot, input logic [1:0] sel);
    if (sel[1])      return 8'h00;
    else if (sel[0]) return top_boot ? DEV_CODE_TOP : DEV_CODE_BOT;
    else             return MFR_CODE;
  endfunction

  // pin value for a read, given width mode and byte lane
  function automatic logic [15:0] lane_value(input logic wide, input logic lane,
                                             input logic [15:0] word);
    if (wide) return word;
    return {8'h00, lane ? word[15:8] : word[7:0]};
  endfunction

endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pflash_deglitch.sv
module pflash_deglitch #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,   // synchronized active-low enable
  output logic act      // qualified active level
);
  localparam int CW = (GLITCH_CYC > 1) ? $clog2(GLITCH_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              low_cnt <= '0;
    else if (pin_n)          low_cnt <= '0;
    else if (low_cnt != LAST) low_cnt <= low_cnt + 1'b1;

  assign act = !pin_n && (low_cnt == LAST);

  if (GLITCH_CYC > 1) begin : g_chk
    // a qualified level never starts on the first low sample (R7)
    assert_no_first_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act) |-> !$past(pin_n));
  end
endmodule

// File: rtl/pflash_front.sv
module pflash_front
  import pflash_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYC  = 4,
  parameter int AUTO_IDLE   = 64,
  parameter bit TOP_BOOT    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              bw16,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       dq_in,
  input  logic              id_mode,
  input  logic [15:0]       arr_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       dq_out,
  output logic              dq_oe_lo,
  output logic              dq_oe_hi,
  output logic              cmd_valid,
  output logic [ADDR_W:0]   cmd_addr,
  output logic [15:0]       cmd_data,
  output logic              wr_proto_err,
  output logic              standby,
  output logic              auto_standby,
  output logic [2:0]        bus_op
);
  localparam int SW = 4 + ADDR_W + 16;
  localparam int IW = $clog2(AUTO_IDLE + 1);
  localparam logic [SW-1:0] SYNC_RST = {4'b1111, {(ADDR_W + 16){1'b0}}};
  localparam logic [IW-1:0] IDLE_MAX = IW'(AUTO_IDLE);

  // ---- synchronized pin image (controls, address, data kept aligned)
  logic [SW-1:0] pins_s;
  logic ce_s, oe_s, we_s, bw16_s;
  logic [ADDR_W-1:0] addr_s;
  logic [15:0] dq_s;

  pflash_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ce_n, oe_n, we_n, bw16, addr, dq_in}), .q(pins_s));

  assign {ce_s, oe_s, we_s, bw16_s, addr_s, dq_s} = pins_s;

  // ---- glitch-qualified enables
  logic ce_act, we_act;
  pflash_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_ce_flt (
    .clk(clk), .rst_n(rst_n), .pin_n(ce_s), .act(ce_act));
  pflash_deglitch #(.GLITCH_CYC(GLITCH_CYC)) u_we_flt (
    .clk(clk), .rst_n(rst_n), .pin_n(we_s), .act(we_act));

  // ---- named internal events
  logic low_bit, wr_sel, wr_sel_q, wr_start, wr_end, rd_go, idle_hit;
  logic [ADDR_W:0] full_addr, prev_addr;
  logic [ADDR_W:0] lat_addr;
  logic            err_seen;
  logic [IW-1:0]   idle_cnt;

  assign low_bit   = bw16_s ? 1'b0 : dq_s[15];
  assign full_addr = {addr_s, low_bit};
  assign wr_sel    = ce_act && we_act;
  assign wr_start  = wr_sel && !wr_sel_q;   // later falling edge
  assign wr_end    = !wr_sel && wr_sel_q;   // earlier rising edge
  assign rd_go     = ce_act && !oe_s && !we_act;
  assign idle_hit  = (idle_cnt == IDLE_MAX);
  assign rd_addr   = addr_s;

  // ---- write capture
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sel_q     <= 1'b0;
      lat_addr     <= '0;
      err_seen     <= 1'b0;
      cmd_valid    <= 1'b0;
      cmd_addr     <= '0;
      cmd_data     <= '0;
      wr_proto_err <= 1'b0;
    end else begin
      wr_sel_q     <= wr_sel;
      wr_proto_err <= wr_sel && !oe_s;
      if (wr_start) begin
        lat_addr <= full_addr;
        err_seen <= !oe_s;
      end else if (wr_sel && !oe_s) begin
        err_seen <= 1'b1;
      end
      cmd_valid <= wr_end && !err_seen;
      if (wr_end) begin
        cmd_addr <= lat_addr;
        cmd_data <= bw16_s ? dq_s : {8'h00, dq_s[7:0]};
      end
    end

  // ---- read path, idle tracking and operation decode
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_addr    <= '0;
      idle_cnt     <= '0;
      dq_out       <= '0;
      dq_oe_lo     <= 1'b0;
      dq_oe_hi     <= 1'b0;
      standby      <= 1'b1;
      auto_standby <= 1'b0;
      bus_op       <= OP_STANDBY;
    end else begin
      prev_addr <= full_addr;
      if (!rd_go || full_addr != prev_addr) idle_cnt <= '0;
      else if (!idle_hit)                   idle_cnt <= idle_cnt + 1'b1;

      dq_out <= id_mode ? {8'h00, ident_byte(TOP_BOOT, addr_s[1:0])}
                        : lane_value(bw16_s, low_bit, arr_data);
      dq_oe_lo     <= rd_go;
      dq_oe_hi     <= rd_go && bw16_s;
      standby      <= !ce_act;
      auto_standby <= rd_go && idle_hit;

      if (!ce_act)      bus_op <= OP_STANDBY;
      else if (we_act)  bus_op <= OP_WRITE;
      else if (oe_s)    bus_op <= OP_OUT_OFF;
      else if (idle_hit) bus_op <= OP_AUTO_SB;
      else              bus_op <= OP_READ;
    end

  // ---- assertions
  assert_no_drive_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    oe_s |=> (!dq_oe_lo && !dq_oe_hi));
  assert_byte_hi_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bw16_s |=> !dq_oe_hi);
  assert_cmd_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_err_drops_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_proto_err |=> !cmd_valid);
  assert_standby_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> !dq_oe_lo);
  assert_auto_in_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    auto_standby |-> dq_oe_lo);
endmodule

// File: tb/pflash_front_bench.sv
module pflash_front_bench;
  localparam int AW = 12;
  localparam int GL = 3;
  localparam int IDLE = 16;

  typedef struct packed { logic [AW:0] a; logic [15:0] d; } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, bw16 = 1'b1, id_mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq = '0;
  logic [15:0] arr_data;
  logic [AW-1:0] rd_addr, rd_addr_b;
  logic [15:0] dq_out, dq_out_b, cmd_data, cmd_data_b;
  logic dq_oe_lo, dq_oe_hi, cmd_valid, wr_proto_err, standby, auto_standby;
  logic dq_oe_lo_b, dq_oe_hi_b, cmd_valid_b, wr_proto_err_b, standby_b, auto_standby_b;
  logic [AW:0] cmd_addr, cmd_addr_b;
  logic [2:0] bus_op, bus_op_b;

  int total = 0, bad = 0, wcnt = 0;
  item_t exp_q[$];

  always #5 clk = ~clk;

  function automatic logic [15:0] word_at(input logic [AW-1:0] a);
    return {~a[7:0], a[7:0]};
  endfunction
  assign arr_data = word_at(rd_addr);

  pflash_front #(.ADDR_W(AW), .GLITCH_CYC(GL), .AUTO_IDLE(IDLE), .TOP_BOOT(1'b1)) u_pflash_front (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .bw16(bw16),
    .addr(addr), .dq_in(dq), .id_mode(id_mode), .arr_data(arr_data),
    .rd_addr(rd_addr), .dq_out(dq_out), .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .wr_proto_err(wr_proto_err), .standby(standby), .auto_standby(auto_standby), .bus_op(bus_op));

  pflash_front #(.ADDR_W(AW), .GLITCH_CYC(GL), .AUTO_IDLE(IDLE), .TOP_BOOT(1'b0)) u_pflash_front_bb (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .bw16(bw16),
    .addr(addr), .dq_in(dq), .id_mode(id_mode), .arr_data(arr_data),
    .rd_addr(rd_addr_b), .dq_out(dq_out_b), .dq_oe_lo(dq_oe_lo_b), .dq_oe_hi(dq_oe_hi_b),
    .cmd_valid(cmd_valid_b), .cmd_addr(cmd_addr_b), .cmd_data(cmd_data_b),
    .wr_proto_err(wr_proto_err_b), .standby(standby_b), .auto_standby(auto_standby_b), .bus_op(bus_op_b));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: compares every command strobe with the queue head (R3, R4)
  always @(negedge clk) begin : mon
    item_t e;
    if (rst_n && cmd_valid) begin
      wcnt++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected write actual=%h/%h expected=none", cmd_addr, cmd_data);
      end else begin
        e = exp_q.pop_front();
        if (cmd_addr !== e.a || cmd_data !== e.d) begin
          bad++;
          $display("FAIL R3/R4 write actual=%h/%h expected=%h/%h", cmd_addr, cmd_data, e.a, e.d);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int w0;
    cyc(3); rst_n = 1'b1; cyc(4);
    chk("R10", "reset standby", standby, 1);
    chk("R6", "reset drive", {dq_oe_hi, dq_oe_lo}, 0);
    chk("R1", "reset op", bus_op, 0);
    chk("R4", "reset cmd", cmd_valid, 0);

    // read, 16-bit
    addr = 12'h123; ce_n = 0; oe_n = 0; cyc(8);
    chk("R1", "read op", bus_op, 1);
    chk("R2", "read drive", {dq_oe_hi, dq_oe_lo}, 2'b11);
    chk("R2", "read data 123", dq_out, word_at(12'h123));
    chk("R10", "standby in read", standby, 0);
    addr = 12'h0F0; cyc(8);
    chk("R2", "read data 0F0", dq_out, word_at(12'h0F0));
    cyc(IDLE + 6);
    chk("R11", "auto standby", auto_standby, 1);
    chk("R1", "auto op", bus_op, 4);
    addr = 12'h0F1; cyc(4);
    chk("R11", "auto cleared", auto_standby, 0);
    chk("R2", "read data 0F1", dq_out, word_at(12'h0F1));

    // output disable, standby
    oe_n = 1; cyc(6);
    chk("R6", "oe high drive", {dq_oe_hi, dq_oe_lo}, 0);
    chk("R1", "out-off op", bus_op, 3);
    ce_n = 1; cyc(6);
    chk("R1", "standby op", bus_op, 0);
    chk("R10", "standby", standby, 1);

    // write, chip enable falls first, write enable rises first
    addr = 12'h011; ce_n = 0; cyc(4);
    addr = 12'h234; cyc(2);
    we_n = 0; exp_q.push_back('{a: {12'h234, 1'b0}, d: 16'hBEEF}); cyc(6);
    chk("R1", "write op", bus_op, 2);
    addr = 12'h3FF; cyc(3);
    dq = 16'hBEEF; cyc(3);
    we_n = 1; cyc(3);
    dq = 16'h1111; cyc(2);
    ce_n = 1; cyc(6);

    // write, write enable falls first, chip enable rises first
    addr = 12'h055; we_n = 0; cyc(4);
    addr = 12'h0AB; ce_n = 0; exp_q.push_back('{a: {12'h0AB, 1'b0}, d: 16'h5A5A}); cyc(6);
    addr = 12'h777; dq = 16'h5A5A; cyc(2);
    ce_n = 1; cyc(3);
    dq = 16'h2222; cyc(2);
    we_n = 1; cyc(6);
    chk("R4", "two writes seen", wcnt, 2);

    // glitch below threshold: ignored (R7)
    w0 = wcnt;
    addr = 12'h0C0; dq = 16'h0C0C;
    ce_n = 0; we_n = 0; cyc(GL - 1);
    ce_n = 1; we_n = 1;
    for (int i = 0; i < 6; i++) begin
      cyc(1);
      chk("R7", "standby kept in glitch", standby, 1);
    end
    chk("R7", "glitch no write", wcnt, w0);
    // exactly at threshold: accepted (R7)
    addr = 12'h0C1; dq = 16'h0C1C;
    exp_q.push_back('{a: {12'h0C1, 1'b0}, d: 16'h0C1C});
    ce_n = 0; we_n = 0; cyc(GL);
    ce_n = 1; we_n = 1; cyc(8);
    chk("R7", "threshold pulse write", wcnt, w0 + 1);

    // output enable low during write (R5)
    w0 = wcnt;
    addr = 12'h0D0; dq = 16'hDEAD; ce_n = 0; we_n = 0; cyc(6);
    oe_n = 0; cyc(4);
    chk("R5", "proto err", wr_proto_err, 1);
    oe_n = 1; cyc(4);
    ce_n = 1; we_n = 1; cyc(8);
    chk("R5", "write dropped", wcnt, w0);

    // 8-bit mode reads and write (R8)
    bw16 = 0; addr = 12'h045; dq = 16'h0000; ce_n = 0; oe_n = 0; cyc(8);
    chk("R8", "byte read low lane", dq_out, {8'h00, word_at(12'h045)[7:0]});
    chk("R8", "byte hi drive", {dq_oe_hi, dq_oe_lo}, 2'b01);
    dq = 16'h8000; cyc(6);
    chk("R8", "byte read high lane", dq_out, {8'h00, word_at(12'h045)[15:8]});
    oe_n = 1; ce_n = 1; cyc(6);
    addr = 12'h066; dq = 16'hFFC3;
    exp_q.push_back('{a: {12'h066, 1'b1}, d: 16'h00C3});
    ce_n = 0; we_n = 0; cyc(6);
    we_n = 1; cyc(3); ce_n = 1; cyc(6);
    bw16 = 1; dq = 16'h0000; cyc(4);

    // identification reads (R9)
    id_mode = 1; addr = 12'h000; ce_n = 0; oe_n = 0; cyc(8);
    chk("R9", "manufacturer code", dq_out, 16'h0020);
    addr = 12'h001; cyc(6);
    chk("R9", "device code top", dq_out, 16'h00D3);
    chk("R9", "device code bottom", dq_out_b, 16'h00D4);
    addr = 12'h002; cyc(6);
    chk("R9", "a1 high", dq_out, 16'h0000);
    bw16 = 0; addr = 12'h001; cyc(6);
    chk("R9", "device code byte mode", dq_out, 16'h00D3);
    chk("R8", "byte mode hi drive in id", dq_oe_hi, 0);
    oe_n = 1; ce_n = 1; id_mode = 0; bw16 = 1; cyc(6);

    chk("R4", "queue drained", exp_q.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule